// File: doc/BRIEF.md
# Alternating Resonant Pulse Timer

This block produces the gate-drive pulses for the two legs of a series-load-resonant half-bridge from a fast reference clock. Two counts are programmed separately. The on-time count sets the width of every pulse and is intended to equal half a period of the resonant tank. The period count sets the spacing between pulse slots. Power is regulated only by lowering the slot rate. Each pulse slot belongs to one leg, and the legs take turns, so at the fastest rate each leg runs at half the resonant frequency with a quarter duty cycle.

An external regulator (a fast PWM or a hysteresis comparator) drives a gating input, `run_en`. It passes through a two-flop synchronizer and is sampled only at slot boundaries. Because of this, gating never shortens a pulse that has already started. The block keeps the identity of the leg that fired last, and a newly enabled pulse always goes to the other leg, so gated operation cannot build up flux in the transformer core. New counts take effect only at a slot boundary. A period shorter than twice the on-time is raised to twice the on-time. Both outputs come straight from flops.

Top module: `resonant_pulse_timer`

## Requirements
- R1: Each pulse is high for exactly W cycles, where W = `on_cnt` read as an unsigned number, except that 0 is treated as 1.
- R2: While `run_en` stays high, consecutive pulse rising edges (on either leg) are exactly P cycles apart. P = max(`period_cnt`, 2*W), with `period_cnt` unsigned.
- R3: Consecutive pulses alternate between `leg_a` and `leg_b`.
- R4: `leg_a` and `leg_b` are never high together, and the low time between one pulse and the next is at least W cycles.
- R5: While the synchronized `run_en` is low, no new pulse starts. A pulse may start only on a slot boundary, so the distance between two pulse starts is always a multiple of P.
- R6: Dropping `run_en` while a pulse is high does not shorten that pulse.
- R7: After any number of disabled slots, the next pulse goes to the leg opposite the one that fired last.
- R8: Changing `on_cnt` or `period_cnt` during a slot does not alter that slot's pulse or length. The new values take effect from the next slot boundary.
- R9: While `rst_n` is low, both outputs are low. The first pulse after reset is on `leg_a`.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| on_cnt | input | CW | Pulse width in clock cycles (0 acts as 1) |
| period_cnt | input | CW | Slot length in clock cycles, raised to at least twice the pulse width |
| run_en | input | 1 | Asynchronous gating input from the power regulator |
| leg_a | output | 1 | Registered gate drive for leg A |
| leg_b | output | 1 | Registered gate drive for leg B |

## Verification
The hardest case to reach from the ports is an enable edge that arrives inside a running pulse, followed by disabled gaps of different lengths. This is the only situation in which a design that toggles the leg on every slot, instead of on every fired pulse, looks different. The bench watches for each pulse's rising edge and lowers `run_en` while that pulse is still high. It then holds the enable low for a series of gaps of increasing length before re-enabling for a single slot. A similar hook reprograms both counts in the middle of a pulse. The remaining checks come from a sweep over every combination of on-time and period in a four-bit configuration.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {
    LEG_A = 1'b0,
    LEG_B = 1'b1
  } leg_e;
endpackage

// File: rtl/rpt_reset_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module rpt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_ns  <= stage_q;
    end
  end
endmodule

// File: rtl/rpt_en_sync.sv
// Two-flop synchronizer for the asynchronous gating input.
module rpt_en_sync (
  input  logic clk,
  input  logic rst_ns,
  input  logic en_async,
  output logic en_ok
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      meta_q <= 1'b0;
      en_ok  <= 1'b0;
    end else begin
      meta_q <= en_async;
      en_ok  <= meta_q;
    end
  end
endmodule

// File: rtl/rpt_slot_timer.sv
// Slot counter; on-time and period are latched at each slot boundary.
module rpt_slot_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic [CW-1:0] on_cnt,
  input  logic [CW-1:0] period_cnt,
  output logic          slot_load,
  output logic          in_pulse_nxt,
  output logic [CW-1:0] on_len
);
  localparam int PW = CW + 1;

  logic [PW-1:0] cnt_q, cnt_n;
  logic [PW-1:0] per_q, per_n;
  logic [CW-1:0] on_n;
  logic [CW-1:0] on_eff;
  logic [PW-1:0] twice_on, per_req, per_eff;

  // Sanitised programming values
  always_comb begin
    on_eff   = (on_cnt == '0) ? {{(CW-1){1'b0}}, 1'b1} : on_cnt;
    twice_on = {on_eff, 1'b0};
    per_req  = {1'b0, period_cnt};
    per_eff  = (per_req < twice_on) ? twice_on : per_req;
  end

  // Next state
  always_comb begin
    slot_load = (cnt_q == (per_q - 1'b1));
    if (slot_load) begin
      cnt_n = '0;
      on_n  = on_eff;
      per_n = per_eff;
    end else begin
      cnt_n = cnt_q + 1'b1;
      on_n  = on_len;
      per_n = per_q;
    end
    in_pulse_nxt = (cnt_n < {1'b0, on_n});
  end

  // Registers: the reset period of 1 makes the first cycle a boundary
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q  <= '0;
      per_q  <= {{(PW-1){1'b0}}, 1'b1};
      on_len <= '0;
    end else begin
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      on_len <= on_n;
    end
  end
endmodule

// File: rtl/rpt_leg_steer.sv
// Leg selection with fired-leg memory and registered gate outputs.
module rpt_leg_steer
  import rpt_pkg::*;
(
  input  logic clk,
  input  logic rst_ns,
  input  logic slot_load,
  input  logic in_pulse_nxt,
  input  logic en_ok,
  output logic leg_a_q,
  output logic leg_b_q
);
  leg_e next_leg_q, next_leg_n;
  leg_e side_q, side_n;
  logic active_q, active_n;
  logic a_n, b_n;

  always_comb begin
    next_leg_n = next_leg_q;
    side_n     = side_q;
    active_n   = active_q;
    if (slot_load) begin
      active_n = en_ok;
      side_n   = next_leg_q;
      if (en_ok) begin
        next_leg_n = (next_leg_q == LEG_A) ? LEG_B : LEG_A;
      end
    end
    a_n = active_n && (side_n == LEG_A) && in_pulse_nxt;
    b_n = active_n && (side_n == LEG_B) && in_pulse_nxt;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      next_leg_q <= LEG_A;
      side_q     <= LEG_A;
      active_q   <= 1'b0;
      leg_a_q    <= 1'b0;
      leg_b_q    <= 1'b0;
    end else begin
      next_leg_q <= next_leg_n;
      side_q     <= side_n;
      active_q   <= active_n;
      leg_a_q    <= a_n;
      leg_b_q    <= b_n;
    end
  end
endmodule

// File: rtl/resonant_pulse_timer.sv
module resonant_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] on_cnt,
  input  logic [CW-1:0] period_cnt,
  input  logic          run_en,
  output logic          leg_a,
  output logic          leg_b
);
  logic          rst_ns;
  logic          en_ok;
  logic          slot_load;
  logic          in_pulse_nxt;
  logic [CW-1:0] on_len;

  rpt_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  rpt_en_sync u_en (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .en_async (run_en),
    .en_ok    (en_ok)
  );

  rpt_slot_timer #(.CW(CW)) u_slot (
    .clk          (clk),
    .rst_ns       (rst_ns),
    .on_cnt       (on_cnt),
    .period_cnt   (period_cnt),
    .slot_load    (slot_load),
    .in_pulse_nxt (in_pulse_nxt),
    .on_len       (on_len)
  );

  rpt_leg_steer u_leg (
    .clk          (clk),
    .rst_ns       (rst_ns),
    .slot_load    (slot_load),
    .in_pulse_nxt (in_pulse_nxt),
    .en_ok        (en_ok),
    .leg_a_q      (leg_a),
    .leg_b_q      (leg_b)
  );
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          leg_a,
  input logic          leg_b,
  input logic          en_ok,
  input logic [CW-1:0] on_len
);
  logic [CW:0] run_len;
  logic        prev_a, prev_b, last_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      prev_a  <= 1'b0;
      prev_b  <= 1'b0;
      last_a  <= 1'b0;
    end else begin
      run_len <= (leg_a || leg_b) ? run_len + 1'b1 : '0;
      prev_a  <= leg_a;
      prev_b  <= leg_b;
      if (leg_a && !prev_a) last_a <= 1'b1;
      if (leg_b && !prev_b) last_a <= 1'b0;
    end
  end

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_a && leg_b));

  a_r1_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(leg_a || leg_b) |-> (run_len == {1'b0, on_len}));

  a_r3_alternate_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg_a) |-> !last_a);

  a_r7_alternate_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg_b) |-> last_a);

  a_r5_gate_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(leg_a) || $rose(leg_b)) |-> $past(en_ok));
endmodule

bind resonant_pulse_timer rpt_checker #(.CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_ns),
  .leg_a  (leg_a),
  .leg_b  (leg_b),
  .en_ok  (en_ok),
  .on_len (on_len)
);

// File: tb/tb_resonant_pulse_timer.sv
`timescale 1ns/1ps
module tb_resonant_pulse_timer;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] on_cnt = 4'd2;
  logic [CW-1:0] period_cnt = 4'd7;
  logic          run_en = 1'b1;
  logic          leg_a, leg_b;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int overlap = 0;
  int expect_leg = 0;

  resonant_pulse_timer #(.CW(CW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_cnt     (on_cnt),
    .period_cnt (period_cnt),
    .run_en     (run_en),
    .leg_a      (leg_a),
    .leg_b      (leg_b)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && leg_a && leg_b) overlap++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int weff(input int o);
    return (o == 0) ? 1 : o;
  endfunction

  function automatic int peff(input int o, input int p);
    return (p < 2 * weff(o)) ? 2 * weff(o) : p;
  endfunction

  // Caller is at a negedge with both legs low. mode 1 drops run_en and
  // mode 2 reprograms the counts as soon as the pulse is seen high.
  task automatic grab(input int mode, output int leg, output int start, output int width);
    int t = 0;
    width = 0; start = -1; leg = -1;
    while (!(leg_a || leg_b) && t < 400) begin
      @(negedge clk);
      t++;
    end
    if (t >= 400) begin
      chk(1'b0, "R5 pulse timeout", t, 0);
      return;
    end
    start = cyc;
    leg = leg_a ? 0 : 1;
    if (mode == 1) run_en = 1'b0;
    if (mode == 2) begin
      on_cnt = 4'd5;
      period_cnt = 4'd0;
    end
    while ((leg_a || leg_b) && width < 100) begin
      width++;
      @(negedge clk);
    end
    chk(leg == expect_leg, "R3/R7 leg alternation", leg, expect_leg);
    expect_leg = 1 - leg;
  endtask

  initial begin
    #1500000;
    chk(1'b0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lg, s1, w1, s2, w2, s3, w3, ref_s;
    // R9: outputs held low in reset
    repeat (4) @(negedge clk);
    chk(!leg_a && !leg_b, "R9 outputs low in reset", {leg_a, leg_b}, 0);
    rst_n = 1'b1;
    expect_leg = 0;
    grab(0, lg, s1, w1);
    chk(lg == 0, "R9 first pulse on leg A", lg, 0);
    chk(w1 == 2, "R1 width after reset", w1, 2);

    // Sweep every on/period combination with enable held high
    for (int o = 0; o < 16; o++) begin
      for (int p = 0; p < 16; p++) begin
        on_cnt = o[CW-1:0];
        period_cnt = p[CW-1:0];
        grab(0, lg, s1, w1);
        grab(0, lg, s2, w2);
        grab(0, lg, s3, w3);
        chk(w1 == weff(o), "R1 width", w1, weff(o));
        chk(w2 == weff(o), "R1 width", w2, weff(o));
        chk(s2 - s1 == peff(o, p), "R2 spacing", s2 - s1, peff(o, p));
        chk(s3 - s2 == peff(o, p), "R2 spacing", s3 - s2, peff(o, p));
        chk(s2 - (s1 + w1) >= w1, "R4 off-time", s2 - (s1 + w1), w1);
      end
    end

    // Gating at slot boundaries, with gaps of varying length
    on_cnt = 4'd2;
    period_cnt = 4'd7;
    grab(0, lg, s1, w1);
    grab(0, lg, ref_s, w1);
    run_en = 1'b0;
    begin
      int seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (leg_a || leg_b) seen++;
      end
      chk(seen == 0, "R5 no pulse while disabled", seen, 0);
    end
    for (int k = 0; k < 7; k++) begin
      int seen = 0;
      run_en = 1'b1;
      grab(1, lg, s1, w1);
      chk(w1 == 2, "R6 pulse not shortened", w1, 2);
      chk((s1 - ref_s) % 7 == 0, "R5 start on slot boundary", (s1 - ref_s) % 7, 0);
      repeat (3 + 4 * k) begin
        @(negedge clk);
        if (leg_a || leg_b) seen++;
      end
      chk(seen == 0, "R5 single slot per burst", seen, 0);
    end

    // R8: reprogram in the middle of a pulse
    run_en = 1'b1;
    grab(0, lg, s1, w1);
    grab(2, lg, s1, w1);
    grab(0, lg, s2, w2);
    grab(0, lg, s3, w3);
    chk(w1 == 2, "R8 running pulse keeps width", w1, 2);
    chk(s2 - s1 == 7, "R8 running slot keeps length", s2 - s1, 7);
    chk(w2 == 5, "R8 new width at next slot", w2, 5);
    chk(s3 - s2 == 10, "R8 new period clamped", s3 - s2, 10);

    chk(overlap == 0, "R4 legs never overlap", overlap, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule